// File: doc/BRIEF.md
# Store-Snooping Instruction Invalidation Unit

This unit sits on the committed-store path of a pipelined core and keeps instruction-side structures coherent with data writes. While snooping is switched on, every store accepted from the store unit is copied in one cycle into a set of small queues, one per instruction-side consumer. Each queue turns the store address into that consumer's index: a cache line index for the instruction cache, a word index for the branch predictor table. It then hands the index to the consumer over a valid/ready handshake.

Software turns snooping on through a control register at a fixed CSR address. It leaves snooping on for as long as code may be rewritten. Before it jumps to rewritten code, it polls a busy flag until all queues have drained. The register resets to off. A build-time parameter can remove the whole mechanism, which leaves the store path as plain wires. Stores are forwarded to memory unchanged. The only cost of snooping is that the store unit is held off while any queue is full.

Top module: `store_snoop_inval`

## Requirements
- R1: With SNOOP_PRESENT = 0, st_ready equals mem_ready and mem_valid equals st_valid in every cycle. inval_valid and busy stay 0, and csr_rdata reads 0.
- R2: A write (csr_we high) at csr_addr equal to CTRL_CSR_ADDR (default 12'h7C0) loads csr_wdata into the enable bit, and the new value takes effect from the next cycle. csr_rdata shows the enable bit while csr_addr equals CTRL_CSR_ADDR and 0 otherwise. Writes to any other address have no effect.
- R3: Reset is synchronous and active-high. After reset the enable bit is 0, all queues are empty, every inval_valid is 0 and busy is 0.
- R4: mem_addr always equals st_addr. mem_valid is high when st_valid is high and the store is not held off. A store is accepted in a cycle where st_valid and st_ready are both high.
- R5: While enabled, st_ready and mem_valid are low in any cycle where any queue holds QUEUE_DEPTH entries. This holds even if that queue is being drained in the same cycle.
- R6: A store accepted while enabled is written into every queue in the same cycle. From the next cycle, every inval_valid is high.
- R7: Queues with an even sink number (sink 0 is the instruction cache) carry st_addr[LINE_OFFS_W +: LINE_IDX_W]. Queues with an odd sink number (the branch predictor) carry st_addr[2 +: BP_IDX_W]. Sink k uses inval_idx[k*IDX_W +: IDX_W], zero-extended to IDX_W = max(LINE_IDX_W, BP_IDX_W).
- R8: Each queue presents its entries in store order. It removes one entry in a cycle where inval_valid and inval_ready are both high, and holds its output unchanged otherwise.
- R9: While disabled, stores are never enqueued and never held off. Entries already queued keep draining.
- R10: busy is high exactly when at least one queue is non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Control register write strobe |
| csr_addr | input | CSR_AW | Control register address |
| csr_wdata | input | 1 | Value written to the enable bit |
| csr_rdata | output | 1 | Enable bit when csr_addr matches, else 0 |
| st_valid | input | 1 | Committed store offered |
| st_addr | input | ADDR_W | Store byte address |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| mem_valid | output | 1 | Store forwarded to memory |
| mem_addr | output | ADDR_W | Forwarded store address |
| mem_ready | input | 1 | Memory side can take a store |
| inval_valid | output | NUM_SINKS | Per-consumer invalidate request |
| inval_idx | output | NUM_SINKS*IDX_W | Per-consumer index, sink k at k*IDX_W |
| inval_ready | input | NUM_SINKS | Per-consumer acceptance |
| busy | output | 1 | Some invalidation still queued |

## Verification
A queue occupancy that is off by one shows up within one cycle as a wrong st_ready once the queue should be full. If the count is too low, the queue overwrites a pending entry, and that surfaces as a wrong index when the entry drains. A stale read pointer delivers an out-of-order or repeated index on the first handshake after it goes wrong. A lost enable bit shows on csr_rdata and on the next store, which either fails to raise inval_valid or is stalled when it should not be. The bench compares every output with a behavioural model on every cycle, so each of these faults is reported in the cycle it first becomes visible.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  typedef enum logic [0:0] {
    SINK_ICACHE = 1'b0,
    SINK_BPRED  = 1'b1
  } sink_kind_e;

  // Even sink numbers feed cache line invalidation, odd ones the predictor.
  function automatic sink_kind_e sink_kind(input int unsigned k);
    return (k % 2 == 0) ? SINK_ICACHE : SINK_BPRED;
  endfunction

  function automatic int unsigned idx_width(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Extract a field of width w starting at bit lo.
  function automatic logic [63:0] addr_field(input logic [63:0] a,
                                             input int unsigned lo,
                                             input int unsigned w);
    logic [63:0] mask;
    mask = ~({64{1'b1}} << w);
    return (a >> lo) & mask;
  endfunction

endpackage

// File: rtl/snoop_enable_reg.sv
module snoop_enable_reg #(
  parameter int unsigned CSR_AW = 12,
  parameter logic [CSR_AW-1:0] CSR_ADDR = 12'h7C0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CSR_AW-1:0] wr_addr,
  input  logic              wr_bit,
  output logic              en_q
);

  logic wr_hit;
  assign wr_hit = wr_en && (wr_addr == CSR_ADDR);

  always_ff @(posedge clk) begin
    if (rst)         en_q <= 1'b0;
    else if (wr_hit) en_q <= wr_bit;
  end

endmodule

// File: rtl/snoop_index_map.sv
module snoop_index_map import snoop_pkg::*; #(
  parameter sink_kind_e  KIND        = SINK_ICACHE,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned LINE_OFFS_W = 5,
  parameter int unsigned LINE_IDX_W  = 7,
  parameter int unsigned BP_IDX_W    = 8,
  parameter int unsigned IDX_W       = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);

  localparam int unsigned WORD_OFFS_W = 2;

  logic [63:0] wide_addr;
  assign wide_addr = 64'(addr);

  if (KIND == SINK_ICACHE) begin : g_line
    assign idx = IDX_W'(addr_field(wide_addr, LINE_OFFS_W, LINE_IDX_W));
  end else begin : g_pred
    assign idx = IDX_W'(addr_field(wide_addr, WORD_OFFS_W, BP_IDX_W));
  end

endmodule

// File: rtl/snoop_queue.sv
module snoop_queue #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  output logic         full,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);

  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_ptr;
  logic [CNT_W-1:0] count;
  logic             push_evt;
  logic             pop_evt;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full      = (count == CNT_W'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = slots[rd_ptr];
  assign push_evt  = push && !full;
  assign pop_evt   = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (push_evt) slots[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_evt) wr_ptr <= bump(wr_ptr);
      if (pop_evt)  rd_ptr <= bump(rd_ptr);
      case ({push_evt, pop_evt})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/store_snoop_inval.sv
module store_snoop_inval import snoop_pkg::*; #(
  parameter bit          SNOOP_PRESENT = 1'b1,
  parameter int unsigned NUM_SINKS     = 2,
  parameter int unsigned QUEUE_DEPTH   = 4,
  parameter int unsigned ADDR_W        = 32,
  parameter int unsigned LINE_OFFS_W   = 5,
  parameter int unsigned LINE_IDX_W    = 7,
  parameter int unsigned BP_IDX_W      = 8,
  parameter int unsigned CSR_AW        = 12,
  parameter logic [CSR_AW-1:0] CTRL_CSR_ADDR = 12'h7C0,
  localparam int unsigned IDX_W = idx_width(LINE_IDX_W, BP_IDX_W)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       csr_we,
  input  logic [CSR_AW-1:0]          csr_addr,
  input  logic                       csr_wdata,
  output logic                       csr_rdata,
  input  logic                       st_valid,
  input  logic [ADDR_W-1:0]          st_addr,
  output logic                       st_ready,
  output logic                       mem_valid,
  output logic [ADDR_W-1:0]          mem_addr,
  input  logic                       mem_ready,
  output logic [NUM_SINKS-1:0]       inval_valid,
  output logic [NUM_SINKS*IDX_W-1:0] inval_idx,
  input  logic [NUM_SINKS-1:0]       inval_ready,
  output logic                       busy
);

  // Internal events, visible to the bound checker.
  logic en_q;
  logic enq_fire;
  logic any_full;

  assign mem_addr = st_addr;

  if (SNOOP_PRESENT) begin : g_snoop
    logic [NUM_SINKS-1:0] q_full;
    logic                 space_ok;

    snoop_enable_reg #(
      .CSR_AW   (CSR_AW),
      .CSR_ADDR (CTRL_CSR_ADDR)
    ) u_enable (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (csr_we),
      .wr_addr (csr_addr),
      .wr_bit  (csr_wdata),
      .en_q    (en_q)
    );

    assign any_full  = |q_full;
    assign space_ok  = !any_full;
    assign st_ready  = mem_ready && (!en_q || space_ok);
    assign mem_valid = st_valid && (!en_q || space_ok);
    assign enq_fire  = st_valid && st_ready && en_q;
    assign busy      = |inval_valid;
    assign csr_rdata = (csr_addr == CTRL_CSR_ADDR) && en_q;

    for (genvar k = 0; k < NUM_SINKS; k++) begin : g_sink
      logic [IDX_W-1:0] idx_in;

      snoop_index_map #(
        .KIND        (sink_kind(k)),
        .ADDR_W      (ADDR_W),
        .LINE_OFFS_W (LINE_OFFS_W),
        .LINE_IDX_W  (LINE_IDX_W),
        .BP_IDX_W    (BP_IDX_W),
        .IDX_W       (IDX_W)
      ) u_map (
        .addr (st_addr),
        .idx  (idx_in)
      );

      snoop_queue #(
        .DEPTH (QUEUE_DEPTH),
        .W     (IDX_W)
      ) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push      (enq_fire),
        .push_data (idx_in),
        .full      (q_full[k]),
        .out_valid (inval_valid[k]),
        .out_data  (inval_idx[k*IDX_W +: IDX_W]),
        .out_ready (inval_ready[k])
      );
    end
  end else begin : g_bare
    assign en_q        = 1'b0;
    assign enq_fire    = 1'b0;
    assign any_full    = 1'b0;
    assign st_ready    = mem_ready;
    assign mem_valid   = st_valid;
    assign inval_valid = '0;
    assign inval_idx   = '0;
    assign busy        = 1'b0;
    assign csr_rdata   = 1'b0;
  end

endmodule

// File: rtl/snoop_checker.sv
module snoop_checker #(
  parameter bit          PRESENT   = 1'b1,
  parameter int unsigned NUM_SINKS = 2,
  parameter int unsigned IDX_W     = 8,
  parameter int unsigned CSR_AW    = 12,
  parameter logic [CSR_AW-1:0] CSR_ADDR = 12'h7C0
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       csr_we,
  input logic [CSR_AW-1:0]          csr_addr,
  input logic                       csr_wdata,
  input logic                       st_valid,
  input logic                       st_ready,
  input logic                       mem_valid,
  input logic                       mem_ready,
  input logic [NUM_SINKS-1:0]       inval_valid,
  input logic [NUM_SINKS*IDX_W-1:0] inval_idx,
  input logic [NUM_SINKS-1:0]       inval_ready,
  input logic                       busy,
  input logic                       en_q,
  input logic                       enq_fire,
  input logic                       any_full
);

  // R2: enable write lands in the next cycle
  a_r2_enable_write: assert property (@(posedge clk) disable iff (rst)
    (PRESENT && csr_we && csr_addr == CSR_ADDR) |=> (en_q == $past(csr_wdata)));

  // R5: a full queue holds off the store path
  a_r5_stall_full: assert property (@(posedge clk) disable iff (rst)
    (en_q && any_full) |-> (!st_ready && !mem_valid));

  // R6: an enqueued store reaches every queue
  a_r6_all_queues: assert property (@(posedge clk) disable iff (rst)
    enq_fire |=> (&inval_valid));

  // R9: disabled snooping never stalls
  a_r9_no_stall_off: assert property (@(posedge clk) disable iff (rst)
    (!en_q && mem_ready) |-> st_ready);

  // R10: idle stays idle without a new enqueue
  a_r10_idle_stays: assert property (@(posedge clk) disable iff (rst)
    (!busy && !enq_fire) |=> !busy);

  // R8: a pending request holds its index until taken
  for (genvar k = 0; k < NUM_SINKS; k++) begin : g_hold
    a_r8_hold_idx: assert property (@(posedge clk) disable iff (rst)
      (inval_valid[k] && !inval_ready[k]) |=>
        (inval_valid[k] && $stable(inval_idx[k*IDX_W +: IDX_W])));
  end

  // R4: a forwarded store implies an offered store
  a_r4_forward: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> st_valid);

endmodule

bind store_snoop_inval snoop_checker #(
  .PRESENT   (SNOOP_PRESENT),
  .NUM_SINKS (NUM_SINKS),
  .IDX_W     (IDX_W),
  .CSR_AW    (CSR_AW),
  .CSR_ADDR  (CTRL_CSR_ADDR)
) u_snoop_checker (
  .clk         (clk),
  .rst         (rst),
  .csr_we      (csr_we),
  .csr_addr    (csr_addr),
  .csr_wdata   (csr_wdata),
  .st_valid    (st_valid),
  .st_ready    (st_ready),
  .mem_valid   (mem_valid),
  .mem_ready   (mem_ready),
  .inval_valid (inval_valid),
  .inval_idx   (inval_idx),
  .inval_ready (inval_ready),
  .busy        (busy),
  .en_q        (en_q),
  .enq_fire    (enq_fire),
  .any_full    (any_full)
);

// File: tb/test_store_snoop_inval.sv
module test_store_snoop_inval;

  localparam int CLK_PERIOD = 10;
  localparam int NS     = 3;
  localparam int DEPTH  = 4;
  localparam int AW     = 32;
  localparam int LOFF   = 4;
  localparam int LIDX   = 6;
  localparam int BPIDX  = 5;
  localparam int IDXW   = 6;
  localparam logic [11:0] CSR = 12'h7C0;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic            rst = 1'b1;
  logic            csr_we = 1'b0;
  logic [11:0]     csr_addr = '0;
  logic            csr_wdata = 1'b0;
  logic            st_valid = 1'b0;
  logic [AW-1:0]   st_addr = '0;
  logic            mem_ready = 1'b0;
  logic [NS-1:0]   inval_ready = '0;

  logic            csr_rdata, st_ready, mem_valid, busy;
  logic [AW-1:0]   mem_addr;
  logic [NS-1:0]   inval_valid;
  logic [NS*IDXW-1:0] inval_idx;

  logic            b_csr_rdata, b_st_ready, b_mem_valid, b_busy;
  logic [AW-1:0]   b_mem_addr;
  logic [NS-1:0]   b_inval_valid;
  logic [NS*IDXW-1:0] b_inval_idx;

  store_snoop_inval #(
    .SNOOP_PRESENT(1'b1), .NUM_SINKS(NS), .QUEUE_DEPTH(DEPTH), .ADDR_W(AW),
    .LINE_OFFS_W(LOFF), .LINE_IDX_W(LIDX), .BP_IDX_W(BPIDX),
    .CSR_AW(12), .CTRL_CSR_ADDR(CSR)
  ) i_store_snoop_inval (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .st_valid(st_valid),
    .st_addr(st_addr), .st_ready(st_ready), .mem_valid(mem_valid),
    .mem_addr(mem_addr), .mem_ready(mem_ready), .inval_valid(inval_valid),
    .inval_idx(inval_idx), .inval_ready(inval_ready), .busy(busy)
  );

  store_snoop_inval #(
    .SNOOP_PRESENT(1'b0), .NUM_SINKS(NS), .QUEUE_DEPTH(DEPTH), .ADDR_W(AW),
    .LINE_OFFS_W(LOFF), .LINE_IDX_W(LIDX), .BP_IDX_W(BPIDX),
    .CSR_AW(12), .CTRL_CSR_ADDR(CSR)
  ) i_store_snoop_inval_bare (
    .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(b_csr_rdata), .st_valid(st_valid),
    .st_addr(st_addr), .st_ready(b_st_ready), .mem_valid(b_mem_valid),
    .mem_addr(b_mem_addr), .mem_ready(mem_ready), .inval_valid(b_inval_valid),
    .inval_idx(b_inval_idx), .inval_ready(inval_ready), .busy(b_busy)
  );

  int n_checks = 0;
  int n_err = 0;
  int cyc = 0;

  // Behavioural reference state
  bit          m_en = 1'b0;
  int unsigned mq [NS][$];

  function automatic int unsigned exp_idx(input int k, input logic [AW-1:0] a);
    if (k % 2 == 0) return int'((a / (1 << LOFF)) % (1 << LIDX));
    return int'((a / 4) % (1 << BPIDX));
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual=%0d cycles expected=%0d at most", cyc, WD_LIMIT);
      summary();
      $finish;
    end
  end

  task automatic step(input bit r, input bit sv, input logic [AW-1:0] a,
                      input bit mr, input logic [NS-1:0] ir,
                      input bit we, input logic [11:0] ca, input bit wd);
    bit space;
    bit acc;
    bit any;
    rst = r; st_valid = sv; st_addr = a; mem_ready = mr; inval_ready = ir;
    csr_we = we; csr_addr = ca; csr_wdata = wd;
    #1;
    space = 1'b1;
    any = 1'b0;
    for (int k = 0; k < NS; k++) begin
      if (mq[k].size() >= DEPTH) space = 1'b0;
      if (mq[k].size() > 0) any = 1'b1;
    end
    if (!r) begin
      chk(m_en ? "R5" : "R9", st_ready, mr && (!m_en || space));
      chk("R4", mem_valid, sv && (!m_en || space));
      chk("R4", mem_addr, a);
      chk("R2", csr_rdata, (ca == CSR) && m_en);
      chk("R10", busy, any);
      for (int k = 0; k < NS; k++) begin
        chk("R6", inval_valid[k], mq[k].size() > 0);
        if (mq[k].size() > 0)
          chk("R7,R8", inval_idx[k*IDXW +: IDXW], mq[k][0]);
      end
      chk("R1", b_st_ready, mr);
      chk("R1", b_mem_valid, sv);
      chk("R1", {b_inval_valid, b_busy, b_csr_rdata}, 0);
    end
    if (r) begin
      m_en = 1'b0;
      for (int k = 0; k < NS; k++) mq[k].delete();
    end else begin
      acc = sv && mr && (!m_en || space);
      for (int k = 0; k < NS; k++)
        if (mq[k].size() > 0 && ir[k]) void'(mq[k].pop_front());
      if (acc && m_en)
        for (int k = 0; k < NS; k++) mq[k].push_back(exp_idx(k, a));
      if (we && ca == CSR) m_en = wd;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic reset_check();
    rst = 1'b0; st_valid = 1'b0; csr_we = 1'b0; csr_addr = CSR; inval_ready = '0;
    #1;
    chk("R3", csr_rdata, 0);
    chk("R3", busy, 0);
    chk("R3", inval_valid, 0);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) step(1, 0, 0, 1, '0, 0, CSR, 0);
    reset_check();

    // R9: disabled, stores flow and nothing queues
    for (int i = 0; i < 4; i++) step(0, 1, 32'h1000 + 32'(i * 4), 1, '0, 0, CSR, 0);
    // R2: wrong address is ignored, then the right one enables
    step(0, 0, 0, 1, '0, 1, CSR + 12'h1, 1);
    step(0, 0, 0, 1, '0, 0, CSR, 0);
    step(0, 0, 0, 1, '0, 1, CSR, 1);
    // R6/R8: stores drained immediately
    for (int i = 0; i < 5; i++) step(0, 1, 32'h2340 + 32'(i * 52), 1, '1, 0, CSR, 0);
    // R5: fill with no consumer ready, then stall
    for (int i = 0; i < 7; i++) step(0, 1, 32'hA000 + 32'(i * 36), 1, '0, 0, CSR, 0);
    // R5: draining a full queue in the same cycle still stalls
    step(0, 1, 32'hBEEF0, 1, 3'b111, 0, CSR, 0);
    // R8: one consumer drains, others hold
    for (int i = 0; i < 6; i++) step(0, 1, 32'hC000 + 32'(i * 20), 1, 3'b010, 0, CSR, 0);
    // R4: memory side not ready
    for (int i = 0; i < 3; i++) step(0, 1, 32'hD00D, 0, 3'b111, 0, CSR, 0);
    // R9: disable with entries still queued; stores not held off, queue drains
    step(0, 1, 32'hE000, 1, '0, 1, CSR, 0);
    for (int i = 0; i < 4; i++) step(0, 1, 32'hE100 + 32'(i * 4), 1, '0, 0, CSR, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 3'b101, 0, CSR, 0);
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 3'b111, 0, CSR, 0);
    // R3: reset with entries queued
    step(0, 0, 0, 1, '0, 1, CSR, 1);
    for (int i = 0; i < 3; i++) step(0, 1, 32'hF0F0 + 32'(i * 64), 1, '0, 0, CSR, 0);
    step(1, 0, 0, 1, '0, 0, CSR, 0);
    reset_check();
    step(0, 1, 32'h1234, 1, '1, 0, CSR, 0);

    // Mixed traffic
    step(0, 0, 0, 1, '0, 1, CSR, 1);
    for (int i = 0; i < 1500; i++) begin
      step(0, ($urandom % 4) != 0, $urandom, ($urandom % 5) != 0,
           NS'($urandom), ($urandom % 23) == 0,
           (($urandom % 3) == 0) ? CSR ^ 12'h004 : CSR, ($urandom % 4) != 0);
    end
    summary();
    $finish;
  end

endmodule